// File: doc/BRIEF.md
# Waveform-Mode Timer Channel

This block is one counter channel of a general-purpose timer, used as a waveform generator. A counter of configurable width (16 bits by default) advances on rising edges of a selected count source. The count source is one of five internal clock inputs or one of three external clock lines. It can be inverted, and it can be gated by an external line. The counter runs through one of four shapes: up-only, up/down, up-only restarting after an RC match, or up/down turning back at RC.

Two outputs, A and B, change level on four kinds of event:
- a compare match (register A for output A, register B for output B),
- an RC compare match,
- an external event edge,
- a software trigger.

Each pairing of event and output carries its own two-bit action: none, set, clear or toggle. The channel gathers match and trigger events into sticky status flags. It also drives an interrupt line through a mask. When the B pin is chosen as the external event source, it becomes an input.

A 32-bit mode word configures the channel. The enable, disable and software-trigger commands arrive as single-cycle pulses.

Top module: `tcw_wave_chan`

## Requirements
- R1: While mode bit 15 is 0 the channel is idle: the counter does not move, outputs A and B keep their levels, the software trigger and external events have no effect, and the B pin is not driven (`tio_b_oe` = 0).
- R2: A `cmd_clk_en` pulse enables the counting clock and a `cmd_clk_dis` pulse disables it (disable wins if both arrive together); status bit 16 shows the enable state. While enabled, not stopped and in waveform mode, the counter moves one step per rising edge of the source picked by mode bits 2:0 (0..4 = `int_clk[0..4]`, 5..7 = `xc[0..2]`).
- R3: Mode bit 3 set makes the counter step on falling edges of the selected source instead. Mode bits 5:4 gate counting: 0 = no gate, 1..3 = count only while `xc[0..2]` is high.
- R4: Waveform select (mode bits 14:13) = 0 counts up by one per step; a step from all-ones to zero sets status bit 0 (overflow). Select 2 behaves the same, except that the step after the counter holds RC loads zero.
- R5: Select 1 counts up to all-ones, then down to zero, then up again, with each extreme held for one step only; overflow is never set in this mode.
- R6: Select 3 counts up to RC, then down to zero, then back up.
- R7: On a counting step whose new counter value equals RA, RB or RC, status bit 2, 3 or 4 is set, and the matching compare event occurs.
- R8: Output A actions: RA compare in mode bits 17:16, RC compare in 19:18, external event in 21:20, software trigger in 23:22. Output B actions: RB compare in 25:24, RC compare in 27:26, external event in 29:28, software trigger in 31:30. Each field is 0 none, 1 set, 2 clear, 3 toggle, and takes effect at the clock edge that detects the event.
- R9: When several events with non-none actions hit one output in one cycle, the software trigger wins over the external event, which wins over RC compare, which wins over the RA/RB compare.
- R10: A software trigger resets the counter to zero, counting up, and clears a stop. The external event source is picked by mode bits 11:10 (0 = B pin, 1..3 = `xc[0..2]`), and its edge by bits 9:8 (0 none, 1 rising, 2 falling, 3 both). An external event sets status bit 7. With mode bit 12 set, it also restarts the counter like a software trigger.
- R11: Mode bit 6 set stops the counter at an RC match until the next trigger. Mode bit 7 set disables the counting clock at an RC match.
- R12: With mode bits 11:10 = 0 the B pin is an input: `tio_b_oe` = 0, and no B action changes output B's level, which status bit 18 mirrors. Status bit 17 mirrors output A.
- R13: Status bits 0, 2, 3, 4 and 7 are sticky until a `stat_clr` pulse (a new event in the same cycle wins over the clear). `irq` is high when any sticky bit is set whose `irq_mask` bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 32 | Mode word (fields as in the requirements) |
| ra | input | CNT_W | Compare register A |
| rb | input | CNT_W | Compare register B |
| rc | input | CNT_W | Compare register C (also period limit) |
| cmd_clk_en | input | 1 | Counting clock enable pulse |
| cmd_clk_dis | input | 1 | Counting clock disable pulse |
| cmd_sw_trig | input | 1 | Software trigger pulse |
| stat_clr | input | 1 | Clears the sticky status flags |
| irq_mask | input | 8 | Interrupt mask over status bits 7:0 |
| int_clk | input | NUM_INT | Internal count sources |
| xc | input | 3 | External clock / event / gate lines |
| tio_b_i | input | 1 | B pin input level |
| tio_a_o | output | 1 | Output A level |
| tio_b_o | output | 1 | Output B level |
| tio_b_oe | output | 1 | B pin output enable |
| cv_o | output | CNT_W | Counter value |
| status_o | output | 32 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
Every result is a single register stage behind the stimulus that causes it: counter value, output levels, status flags and `irq` all move at the first rising clock edge that sees a count-source edge, event edge or command pulse. Source and event edges are found by comparing the present input with a copy registered one edge earlier. The bench therefore drives inputs on the falling clock edge, lets one rising edge pass, and samples on the next falling edge. A count step is a high half-period followed by a low one on the selected source, so a falling-edge source steps only on its second half, and the bench samples between the halves to show that.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

  // mode word field positions
  localparam int CSEL_LSB     = 0;
  localparam int INV_BIT      = 3;
  localparam int GATE_LSB     = 4;
  localparam int STOP_BIT     = 6;
  localparam int DIS_BIT      = 7;
  localparam int EDG_LSB      = 8;
  localparam int ESRC_LSB     = 10;
  localparam int ETRG_BIT     = 12;
  localparam int WSEL_LSB     = 13;
  localparam int WAVE_BIT     = 15;
  localparam int ACT_LSB      = 16;
  localparam int ACT_STRIDE   = 8;

  // status word bit positions
  localparam int ST_OVF  = 0;
  localparam int ST_CPA  = 2;
  localparam int ST_CPB  = 3;
  localparam int ST_CPC  = 4;
  localparam int ST_ETRG = 7;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  function automatic logic act_apply(input logic cur, input logic [1:0] act);
    case (act)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

  // highest-priority event carrying a non-none action
  function automatic logic [1:0] act_pick(
    input logic sw, input logic ext, input logic rcm, input logic cmp,
    input logic [1:0] a_sw, input logic [1:0] a_ext,
    input logic [1:0] a_rc, input logic [1:0] a_cmp);
    if (sw && a_sw != ACT_NONE)   return a_sw;
    if (ext && a_ext != ACT_NONE) return a_ext;
    if (rcm && a_rc != ACT_NONE)  return a_rc;
    if (cmp && a_cmp != ACT_NONE) return a_cmp;
    return ACT_NONE;
  endfunction

  function automatic logic edge_hit(input logic now, input logic prev,
                                    input logic [1:0] sel);
    case (sel)
      2'd1:    return now & ~prev;
      2'd2:    return ~now & prev;
      2'd3:    return now ^ prev;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tcw_clk_sel.sv
module tcw_clk_sel #(
  parameter int NUM_INT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         sel,
  input  logic               inv,
  input  logic [1:0]         gate,
  input  logic [NUM_INT-1:0] int_clk,
  input  logic [2:0]         xc,
  output logic               tick
);
  localparam int NSRC    = 8;
  localparam int XC_BASE = 5;

  logic [NSRC-1:0] src_vec;
  logic [3:0]      gate_vec;
  logic            lvl;
  logic            lvl_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i >= XC_BASE) begin : g_xc
      assign src_vec[i] = xc[i-XC_BASE];
    end else if (i < NUM_INT) begin : g_int
      assign src_vec[i] = int_clk[i];
    end else begin : g_tie
      assign src_vec[i] = 1'b0;
    end
  end

  assign gate_vec = {xc, 1'b1};
  assign lvl      = src_vec[sel] ^ inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign tick = lvl & ~lvl_q & gate_vec[gate];

endmodule

// File: rtl/tcw_evt_det.sv
module tcw_evt_det
  import tcw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src,
  input  logic [1:0] edg,
  input  logic       pin_b,
  input  logic [2:0] xc,
  output logic       ev
);
  logic [3:0] cand;
  logic       lvl;
  logic       lvl_q;

  assign cand = {xc, pin_b};
  assign lvl  = cand[src];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign ev = edge_hit(lvl, lvl_q, edg);

endmodule

// File: rtl/tcw_counter.sv
module tcw_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       wsel,
  input  logic             cpc_stop,
  input  logic             cpc_dis,
  input  logic             cmd_en,
  input  logic             cmd_dis,
  input  logic             trig,
  input  logic             tick,
  input  logic [CNT_W-1:0] ra,
  input  logic [CNT_W-1:0] rb,
  input  logic [CNT_W-1:0] rc,
  output logic [CNT_W-1:0] cv,
  output logic             clk_on,
  output logic             ev_ovf,
  output logic             ev_ra,
  output logic             ev_rb,
  output logic             ev_rc
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             dir_up;
  logic             stopped;
  logic             step;
  logic             updown;
  logic             autorst;
  logic [CNT_W-1:0] top;
  logic [CNT_W-1:0] nxt;
  logic             dir_n;

  assign updown  = wsel[0];
  assign autorst = wsel[1];
  assign top     = autorst ? rc : ALL1;
  assign step    = en && clk_on && !stopped && tick && !trig;

  always_comb begin
    nxt   = cv;
    dir_n = dir_up;
    if (!updown) begin
      nxt = (autorst && cv == rc) ? '0 : cv + ONE;
    end else if (dir_up) begin
      if (cv >= top && cv != '0) begin
        nxt   = cv - ONE;
        dir_n = 1'b0;
      end else begin
        nxt = cv + ONE;
      end
    end else begin
      if (cv == '0) begin
        nxt   = ONE;
        dir_n = 1'b1;
      end else begin
        nxt = cv - ONE;
      end
    end
  end

  assign ev_ovf = step && !updown && cv == ALL1;
  assign ev_ra  = step && nxt == ra;
  assign ev_rb  = step && nxt == rb;
  assign ev_rc  = step && nxt == rc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv      <= '0;
      dir_up  <= 1'b1;
      stopped <= 1'b0;
    end else if (trig) begin
      cv      <= '0;
      dir_up  <= 1'b1;
      stopped <= 1'b0;
    end else if (step) begin
      cv     <= nxt;
      dir_up <= dir_n;
      if (ev_rc && cpc_stop) stopped <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         clk_on <= 1'b0;
    else if (cmd_dis || (ev_rc && cpc_dis)) clk_on <= 1'b0;
    else if (cmd_en)                    clk_on <= 1'b1;
  end

  // R2: without a step or trigger the counter holds
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !trig) |=> $stable(cv));

  // R6: in up/down-to-RC mode, reaching RC turns the count downward
  p_turn_at_rc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wsel == 2'd3 && dir_up && cv == rc && cv != '0) |=> (cv == $past(cv) - ONE));

  // R11: a stopped counter holds until a trigger
  p_stop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !trig) |=> $stable(cv));

endmodule

// File: rtl/tcw_out_ctl.sv
module tcw_out_ctl
  import tcw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ev_sw,
  input  logic       ev_ext,
  input  logic       ev_rc,
  input  logic       ev_cmp,
  input  logic [1:0] a_sw,
  input  logic [1:0] a_ext,
  input  logic [1:0] a_rc,
  input  logic [1:0] a_cmp,
  output logic       q
);
  logic [1:0] act;

  assign act = act_pick(ev_sw, ev_ext, ev_rc, ev_cmp, a_sw, a_ext, a_rc, a_cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= act_apply(q, act);
  end

  // R8: with no event at all the level is kept
  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_sw || ev_ext || ev_rc || ev_cmp) |=> $stable(q));

endmodule

// File: rtl/tcw_wave_chan.sv
module tcw_wave_chan
  import tcw_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_INT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        mode,
  input  logic [CNT_W-1:0]   ra,
  input  logic [CNT_W-1:0]   rb,
  input  logic [CNT_W-1:0]   rc,
  input  logic               cmd_clk_en,
  input  logic               cmd_clk_dis,
  input  logic               cmd_sw_trig,
  input  logic               stat_clr,
  input  logic [7:0]         irq_mask,
  input  logic [NUM_INT-1:0] int_clk,
  input  logic [2:0]         xc,
  input  logic               tio_b_i,
  output logic               tio_a_o,
  output logic               tio_b_o,
  output logic               tio_b_oe,
  output logic [CNT_W-1:0]   cv_o,
  output logic [31:0]        status_o,
  output logic               irq
);
  localparam int NOUT = 2;

  logic       wave;
  logic       b_is_in;
  logic       tick;
  logic       ev_raw;
  logic       ev_ext;
  logic       ev_sw;
  logic       trig;
  logic       clk_on;
  logic       ev_ovf;
  logic       ev_ra;
  logic       ev_rb;
  logic       ev_rc;
  logic [7:0] st_set;
  logic [7:0] sticky;
  logic [NOUT-1:0] out_q;
  logic [NOUT-1:0] out_en;
  logic [NOUT-1:0] cmp_ev;

  assign wave    = mode[WAVE_BIT];
  assign b_is_in = (mode[ESRC_LSB +: 2] == 2'd0);
  assign ev_sw   = wave && cmd_sw_trig;
  assign ev_ext  = wave && ev_raw;
  assign trig    = ev_sw || (ev_ext && mode[ETRG_BIT]);

  tcw_clk_sel #(.NUM_INT(NUM_INT)) u_clk_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (mode[CSEL_LSB +: 3]),
    .inv     (mode[INV_BIT]),
    .gate    (mode[GATE_LSB +: 2]),
    .int_clk (int_clk),
    .xc      (xc),
    .tick    (tick)
  );

  tcw_evt_det u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (mode[ESRC_LSB +: 2]),
    .edg   (mode[EDG_LSB +: 2]),
    .pin_b (tio_b_i),
    .xc    (xc),
    .ev    (ev_raw)
  );

  tcw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (wave),
    .wsel     (mode[WSEL_LSB +: 2]),
    .cpc_stop (mode[STOP_BIT]),
    .cpc_dis  (mode[DIS_BIT]),
    .cmd_en   (cmd_clk_en),
    .cmd_dis  (cmd_clk_dis),
    .trig     (trig),
    .tick     (tick),
    .ra       (ra),
    .rb       (rb),
    .rc       (rc),
    .cv       (cv_o),
    .clk_on   (clk_on),
    .ev_ovf   (ev_ovf),
    .ev_ra    (ev_ra),
    .ev_rb    (ev_rb),
    .ev_rc    (ev_rc)
  );

  assign out_en = {wave && !b_is_in, wave};
  assign cmp_ev = {ev_rb, ev_ra};

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    localparam int BASE = ACT_LSB + i * ACT_STRIDE;
    tcw_out_ctl u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (out_en[i]),
      .ev_sw  (ev_sw),
      .ev_ext (ev_ext),
      .ev_rc  (ev_rc),
      .ev_cmp (cmp_ev[i]),
      .a_sw   (mode[BASE+6 +: 2]),
      .a_ext  (mode[BASE+4 +: 2]),
      .a_rc   (mode[BASE+2 +: 2]),
      .a_cmp  (mode[BASE +: 2]),
      .q      (out_q[i])
    );
  end

  always_comb begin
    st_set          = '0;
    st_set[ST_OVF]  = ev_ovf;
    st_set[ST_CPA]  = ev_ra;
    st_set[ST_CPB]  = ev_rb;
    st_set[ST_CPC]  = ev_rc;
    st_set[ST_ETRG] = ev_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sticky <= '0;
    else if (stat_clr) sticky <= st_set;
    else               sticky <= sticky | st_set;
  end

  assign tio_a_o  = out_q[0];
  assign tio_b_o  = out_q[1];
  assign tio_b_oe = wave && !b_is_in;
  assign irq      = |(sticky & irq_mask);
  assign status_o = {13'd0, out_q[1], out_q[0], clk_on, 8'd0, sticky};

  // R12: B level never moves while the B pin is the event input
  p_b_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wave && b_is_in) |=> $stable(tio_b_o));

  // R13: a clear with no new event empties the sticky flags
  p_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && st_set == 8'd0) |=> (status_o[7:0] == 8'd0));

  // R10: software trigger restarts from zero
  p_sw_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sw |=> (cv_o == '0));

endmodule

// File: tb/tcw_wave_chan_tb.sv
module tcw_wave_chan_tb;
  localparam int W  = 8;
  localparam logic [31:0] WV = 32'h0000_8000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   mode = '0;
  logic [W-1:0]  ra = 8'd3, rb = 8'd4, rc = 8'd5;
  logic          cmd_clk_en = 1'b0, cmd_clk_dis = 1'b0, cmd_sw_trig = 1'b0;
  logic          stat_clr = 1'b0;
  logic [7:0]    irq_mask = '0;
  logic [4:0]    int_clk = '0;
  logic [2:0]    xc = '0;
  logic          tio_b_i = 1'b0;
  logic          tio_a_o, tio_b_o, tio_b_oe, irq;
  logic [W-1:0]  cv_o;
  logic [31:0]   status_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tcw_wave_chan #(.CNT_W(W), .NUM_INT(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ra(ra), .rb(rb), .rc(rc),
    .cmd_clk_en(cmd_clk_en), .cmd_clk_dis(cmd_clk_dis), .cmd_sw_trig(cmd_sw_trig),
    .stat_clr(stat_clr), .irq_mask(irq_mask), .int_clk(int_clk), .xc(xc),
    .tio_b_i(tio_b_i), .tio_a_o(tio_a_o), .tio_b_o(tio_b_o), .tio_b_oe(tio_b_oe),
    .cv_o(cv_o), .status_o(status_o), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      int_clk[0] = 1'b1; @(negedge clk);
      int_clk[0] = 1'b0; @(negedge clk);
    end
  endtask

  task automatic pulse_sw();
    cmd_sw_trig = 1'b1; @(negedge clk); cmd_sw_trig = 1'b0;
  endtask

  task automatic pulse_en();
    cmd_clk_en = 1'b1; @(negedge clk); cmd_clk_en = 1'b0;
  endtask

  task automatic pulse_clr();
    stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset cv", cv_o, 0);
    check("R13 reset status", status_o, 0);
    check("R13 reset irq", irq, 0);
    check("R1 reset oe", tio_b_oe, 0);
  endtask

  task automatic t_idle();
    mode = 32'h0040_0000; // sw sets A, but waveform bit clear
    pulse_en();
    tick(2);
    check("R1 idle cv", cv_o, 0);
    pulse_sw(); @(negedge clk);
    check("R1 idle A", tio_a_o, 0);
    check("R2 clock enabled bit", status_o[16], 1);
  endtask

  task automatic t_up();
    mode = WV | (32'd1 << 10) | (32'd1 << 16) | (32'd2 << 18) | (32'd3 << 24);
    pulse_sw(); pulse_clr();
    tick(3);
    check("R7 cv at RA", cv_o, 3);
    check("R8 A set on RA", tio_a_o, 1);
    check("R7 RA flag", status_o[2], 1);
    tick(1);
    check("R8 B toggled on RB", tio_b_o, 1);
    check("R7 RB flag", status_o[3], 1);
    check("R12 B driven", tio_b_oe, 1);
    tick(1);
    check("R4 cv step", cv_o, 5);
    check("R8 A clear on RC", tio_a_o, 0);
    check("R7 RC flag", status_o[4], 1);
    check("R13 A mirror", status_o[17], 0);
    pulse_clr();
    tick(250);
    check("R4 cv all ones", cv_o, 255);
    check("R4 no overflow yet", status_o[0], 0);
    tick(1);
    check("R4 wrap", cv_o, 0);
    check("R4 overflow flag", status_o[0], 1);
  endtask

  task automatic t_updown();
    mode = WV | (32'd1 << 13) | (32'd1 << 10);
    ra = 8'd200; rb = 8'd200;
    pulse_sw(); pulse_clr();
    tick(255);
    check("R5 top", cv_o, 255);
    tick(1);
    check("R5 turn down", cv_o, 254);
    tick(254);
    check("R5 bottom", cv_o, 0);
    tick(1);
    check("R5 turn up", cv_o, 1);
    check("R5 no overflow", status_o[0], 0);
  endtask

  task automatic t_auto();
    mode = WV | (32'd2 << 13) | (32'd1 << 10);
    rc = 8'd4;
    pulse_sw();
    tick(4);
    check("R4 auto at RC", cv_o, 4);
    tick(1);
    check("R4 auto restart", cv_o, 0);
    mode = WV | (32'd3 << 13) | (32'd1 << 10);
    rc = 8'd3;
    pulse_sw();
    tick(3);
    check("R6 up to RC", cv_o, 3);
    tick(1);
    check("R6 down from RC", cv_o, 2);
    tick(2);
    check("R6 down to zero", cv_o, 0);
    tick(1);
    check("R6 up again", cv_o, 1);
  endtask

  task automatic t_stop_dis();
    mode = WV | (32'd1 << 6) | (32'd1 << 10);
    rc = 8'd2;
    pulse_sw();
    tick(3);
    check("R11 stopped at RC", cv_o, 2);
    pulse_sw(); @(negedge clk);
    check("R10 sw restart", cv_o, 0);
    tick(1);
    check("R11 runs after trigger", cv_o, 1);
    mode = WV | (32'd1 << 7) | (32'd1 << 10);
    pulse_sw();
    tick(2);
    check("R11 clock disabled", status_o[16], 0);
    tick(1);
    check("R11 held while disabled", cv_o, 2);
    pulse_en();
    tick(1);
    check("R2 re-enabled count", cv_o, 3);
  endtask

  task automatic t_prio();
    mode = WV | (32'd2 << 10) | (32'd1 << 8) | (32'd1 << 20) | (32'd2 << 18) | (32'd2 << 22);
    rc = 8'd2;
    pulse_sw(); pulse_clr();
    check("R8 sw clear A", tio_a_o, 0);
    tick(1);
    int_clk[0] = 1'b1; xc[1] = 1'b1; @(negedge clk);
    check("R9 ext beats RC", tio_a_o, 1);
    check("R10 ext flag", status_o[7], 1);
    check("R7 RC flag same cycle", status_o[4], 1);
    int_clk[0] = 1'b0; xc[1] = 1'b0; @(negedge clk);
    cmd_sw_trig = 1'b1; xc[1] = 1'b1; @(negedge clk);
    cmd_sw_trig = 1'b0;
    check("R9 sw beats ext", tio_a_o, 0);
    xc[1] = 1'b0; @(negedge clk);
  endtask

  task automatic t_bpin();
    mode = WV | (32'd1 << 10) | (32'd2 << 30);
    pulse_sw(); @(negedge clk);
    check("R8 B clear by sw", tio_b_o, 0);
    mode = WV | (32'd1 << 8) | (32'd3 << 28) | (32'd1 << 30) | (32'd3 << 20);
    pulse_clr(); @(negedge clk);
    check("R12 B not driven", tio_b_oe, 0);
    tio_b_i = 1'b1; @(negedge clk);
    check("R10 B pin event toggles A", tio_a_o, 1);
    check("R10 B pin event flag", status_o[7], 1);
    check("R12 B ignores ext action", status_o[18], 0);
    tio_b_i = 1'b0;
    pulse_sw(); @(negedge clk);
    check("R12 B ignores sw action", status_o[18], 0);
  endtask

  task automatic t_ext_trig();
    mode = WV | (32'd1 << 10) | (32'd1 << 8) | (32'd1 << 12);
    rc = 8'd200;
    pulse_sw();
    tick(5);
    check("R10 count before ext trig", cv_o, 5);
    xc[0] = 1'b1; @(negedge clk);
    check("R10 ext trig restarts", cv_o, 0);
    xc[0] = 1'b0; @(negedge clk);
  endtask

  task automatic t_gate_inv();
    mode = WV | (32'd1 << 10) | (32'd1 << 4);
    pulse_sw();
    tick(2);
    check("R3 gated off", cv_o, 0);
    xc[0] = 1'b1;
    tick(2);
    check("R3 gated on", cv_o, 2);
    xc[0] = 1'b0;
    mode = WV | (32'd1 << 10) | (32'd1 << 3);
    @(negedge clk);
    pulse_sw(); @(negedge clk);
    int_clk[0] = 1'b1; @(negedge clk);
    check("R3 no step on rising", cv_o, 0);
    int_clk[0] = 1'b0; @(negedge clk);
    check("R3 step on falling", cv_o, 1);
  endtask

  task automatic t_irq();
    mode = WV | (32'd1 << 10);
    rc = 8'd3;
    irq_mask = 8'h10;
    pulse_sw(); pulse_clr();
    tick(2);
    check("R13 irq low", irq, 0);
    tick(1);
    check("R13 irq on RC", irq, 1);
    pulse_clr();
    check("R13 irq cleared", irq, 0);
    check("R13 flag cleared", status_o[4], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_up();
    t_updown();
    t_auto();
    t_stop_dis();
    t_prio();
    t_bpin();
    t_ext_trig();
    t_gate_inv();
    t_irq();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule